// File: doc/BRIEF.md
# JTAG Programming-Entry Data Registers

This block holds the test data registers that stand between a JTAG test access port and a device's programming mode. An existing TAP controller supplies the test clock, the capture, shift and update strobes, and one select line per register. The block returns a single serial output from whichever register is selected.

The block has three registers:
- **Reset register (one bit).** While it holds a 1, it drives the device reset. The register has no update stage, so a new value reaches the reset output on the same clock edge that shifts it in.
- **Unlock register (16 bits).** It opens programming mode only while its contents equal the unlock word 0xA370.
- **Command register (15 bits).** It captures the result of the previous command. It then shifts that result out while a new command shifts in. On update, it hands the new command to the programming engine, but only while programming mode is open.

Top module: `jtag_prog_dregs`

## Requirements
- R1: While `por_n` is low, `prog_on`, `dev_reset` and `cmd_valid` are 0, and `tdo` is 0 when no select is high. `por_n` clears all registers asynchronously.
- R2: Each TCK rising edge with `sel_rst` and `shift_dr` both high loads `tdi` into the reset register. `dev_reset` and `tdo` show the new value right after that edge, with no update strobe needed.
- R3: `prog_on` is 1 exactly when the 16-bit unlock register holds 0xA370 (binary 1010_0011_0111_0000). Every other value, including values that differ in a single bit, gives 0.
- R4: With `sel_en` and `shift_dr` high, the unlock register shifts right one place per TCK edge, taking `tdi` into bit 15. `tdo` shows bit 0, so the old contents leave LSB first.
- R5: A TCK edge with `leave_prog` high zeroes the unlock register. `prog_on` is 0 after that edge, and this takes priority over shifting.
- R6: A TCK edge with `capture_dr` and `sel_cmd` high loads `result_in` into the command register. Each following shift edge moves it right one place, with `tdi` entering bit 14 and bit 0 on `tdo`.
- R7: A TCK edge with `update_dr` and `sel_cmd` high while `prog_on` is 1 copies the command register to `cmd_data`. It also raises `cmd_valid` for exactly the one following cycle.
- R8: An update edge while `prog_on` is 0 is ignored: `cmd_valid` stays 0 and `cmd_data` keeps its value.
- R9: With no select high, `tdo` is 0. When more than one select is high, the priority is reset register, then unlock register, then command register.
- R10: Shift strobes without a register's select leave that register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tdi | input | 1 | Serial data in |
| capture_dr | input | 1 | Capture strobe from the TAP |
| shift_dr | input | 1 | Shift strobe from the TAP |
| update_dr | input | 1 | Update strobe from the TAP |
| sel_rst | input | 1 | Selects the reset register |
| sel_en | input | 1 | Selects the unlock register |
| sel_cmd | input | 1 | Selects the command register |
| leave_prog | input | 1 | Clears the unlock register when programming mode is left |
| result_in | input | 15 | Result of the previous command, taken on capture |
| tdo | output | 1 | Serial data out |
| dev_reset | output | 1 | Device reset request |
| prog_on | output | 1 | Programming mode unlocked |
| cmd_data | output | 15 | Last command accepted |
| cmd_valid | output | 1 | One-cycle pulse when a command is accepted |

## Verification
The bench targets these corner cases and the failures they would expose:

- **Unlock words close to 0xA370.** Words such as 0xA371, 0x2370 and 0xA3F0 must not unlock. A comparator that masks bits would open programming on them.
- **Shift direction.** The bench reads each old unlock word back serially and compares it bit by bit. A register that shifts MSB first, or takes `tdi` into the wrong end, fails this check.
- **Reset output timing.** `dev_reset` must change on the same edge that shifts the new value in. A version that latched the reset register on update would lag by one update.
- **Commands while locked.** After `leave_prog`, the bench sends a command. Forwarding it, or overwriting `cmd_data`, shows that the unlock gate is missing.

// File: rtl/jtag_prog_dregs.sv
`timescale 1ns/1ps
module jtag_prog_dregs #(
  parameter int          CMD_W  = 15,
  parameter int          KEY_W  = 16,
  parameter logic [15:0] UNLOCK = 16'hA370
) (
  input  logic             tck,
  input  logic             por_n,
  input  logic             tdi,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             sel_rst,
  input  logic             sel_en,
  input  logic             sel_cmd,
  input  logic             leave_prog,
  input  logic [CMD_W-1:0] result_in,
  output logic             tdo,
  output logic             dev_reset,
  output logic             prog_on,
  output logic [CMD_W-1:0] cmd_data,
  output logic             cmd_valid
);

  logic             rst_q;
  logic [KEY_W-1:0] key_q;
  logic [CMD_W-1:0] cmd_q;

  always_ff @(posedge tck or negedge por_n)
    if (!por_n)                  rst_q <= 1'b0;
    else if (sel_rst && shift_dr) rst_q <= tdi;

  always_ff @(posedge tck or negedge por_n)
    if (!por_n)                  key_q <= '0;
    else if (leave_prog)         key_q <= '0;
    else if (sel_en && shift_dr) key_q <= {tdi, key_q[KEY_W-1:1]};

  always_ff @(posedge tck or negedge por_n)
    if (!por_n)                     cmd_q <= '0;
    else if (sel_cmd && capture_dr) cmd_q <= result_in;
    else if (sel_cmd && shift_dr)   cmd_q <= {tdi, cmd_q[CMD_W-1:1]};

  always_ff @(posedge tck or negedge por_n)
    if (!por_n) begin
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= sel_cmd && update_dr && prog_on;
      if (sel_cmd && update_dr && prog_on) cmd_data <= cmd_q;
    end

  assign dev_reset = rst_q;
  assign prog_on   = (key_q == UNLOCK[KEY_W-1:0]);
  assign tdo       = sel_rst ? rst_q    :
                     sel_en  ? key_q[0] :
                     sel_cmd ? cmd_q[0] : 1'b0;

endmodule

module jtag_prog_dregs_chk (
  input logic tck,
  input logic por_n,
  input logic tdi,
  input logic shift_dr,
  input logic update_dr,
  input logic sel_rst,
  input logic sel_en,
  input logic sel_cmd,
  input logic leave_prog,
  input logic tdo,
  input logic dev_reset,
  input logic prog_on,
  input logic cmd_valid
);
  assert_rst_follows_R2: assert property (@(posedge tck) disable iff (!por_n)
    (sel_rst && shift_dr) |=> (dev_reset == $past(tdi)));
  assert_exit_locks_R5: assert property (@(posedge tck) disable iff (!por_n)
    leave_prog |=> !prog_on);
  assert_valid_from_update_R7: assert property (@(posedge tck) disable iff (!por_n)
    cmd_valid |-> $past(update_dr && sel_cmd));
  assert_valid_needs_unlock_R8: assert property (@(posedge tck) disable iff (!por_n)
    cmd_valid |-> $past(prog_on));
  assert_tdo_idle_R9: assert property (@(posedge tck) disable iff (!por_n)
    (!sel_rst && !sel_en && !sel_cmd) |-> !tdo);
  assert_key_hold_R10: assert property (@(posedge tck) disable iff (!por_n)
    (!sel_en && !leave_prog) |=> $stable(prog_on));
endmodule

bind jtag_prog_dregs jtag_prog_dregs_chk u_chk (
  .tck(tck), .por_n(por_n), .tdi(tdi), .shift_dr(shift_dr), .update_dr(update_dr),
  .sel_rst(sel_rst), .sel_en(sel_en), .sel_cmd(sel_cmd), .leave_prog(leave_prog),
  .tdo(tdo), .dev_reset(dev_reset), .prog_on(prog_on), .cmd_valid(cmd_valid)
);

// File: tb/test_jtag_prog_dregs.sv
`timescale 1ns/1ps
module test_jtag_prog_dregs;
  logic tck = 0, por_n = 0, tdi = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0;
  logic sel_rst = 0, sel_en = 0, sel_cmd = 0, leave_prog = 0;
  logic [14:0] result_in = '0;
  logic tdo, dev_reset, prog_on, cmd_valid;
  logic [14:0] cmd_data;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #10 tck = ~tck;

  jtag_prog_dregs i_jtag_prog_dregs (
    .tck(tck), .por_n(por_n), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .sel_rst(sel_rst),
    .sel_en(sel_en), .sel_cmd(sel_cmd), .leave_prog(leave_prog),
    .result_in(result_in), .tdo(tdo), .dev_reset(dev_reset),
    .prog_on(prog_on), .cmd_data(cmd_data), .cmd_valid(cmd_valid)
  );

  typedef struct packed { logic [15:0] word; logic unlock; } vec_t;
  localparam vec_t VECS [7] = '{
    '{16'hA370, 1'b1}, '{16'hA371, 1'b0}, '{16'h2370, 1'b0}, '{16'h0000, 1'b0},
    '{16'hFFFF, 1'b0}, '{16'hA3F0, 1'b0}, '{16'hA370, 1'b1}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge tck); @(negedge tck);
  endtask

  task automatic shift_bits(input int n, input logic [15:0] din, output logic [15:0] dout);
    dout = '0;
    shift_dr = 1;
    for (int i = 0; i < n; i++) begin
      tdi = din[i];
      #1 dout[i] = tdo;
      cyc();
    end
    shift_dr = 0; tdi = 0;
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [15:0] dout;
    logic [15:0] prev;
    @(negedge tck); cyc();
    check("R1 prog_on", prog_on, 0);
    check("R1 dev_reset", dev_reset, 0);
    check("R1 cmd_valid", cmd_valid, 0);
    check("R1 tdo", tdo, 0);
    por_n = 1; cyc();

    prev = 16'h0000;
    sel_en = 1;
    for (int v = 0; v < 7; v++) begin
      shift_bits(16, VECS[v].word, dout);
      check("R3 prog_on for word", prog_on, VECS[v].unlock);
      check("R4 old word out LSB first", dout, prev);
      prev = VECS[v].word;
    end
    sel_en = 0;

    sel_rst = 1;
    shift_bits(1, 16'h1, dout);
    check("R2 dev_reset set without update", dev_reset, 1);
    check("R2 tdo shows reset bit", tdo, 1);
    sel_rst = 0;
    shift_bits(3, 16'h0, dout);
    check("R10 reset bit held", dev_reset, 1);
    check("R10 prog_on held", prog_on, 1);
    check("R9 tdo idle", tdo, 0);
    sel_rst = 1;
    shift_bits(1, 16'h0, dout);
    check("R2 dev_reset cleared", dev_reset, 0);
    sel_rst = 0;

    sel_cmd = 1; result_in = 15'h5A3C;
    capture_dr = 1; cyc(); capture_dr = 0;
    shift_bits(15, 16'h2B61, dout);
    check("R6 result shifted out", dout[14:0], 15'h5A3C);
    update_dr = 1; cyc(); update_dr = 0;
    check("R7 cmd_valid pulse", cmd_valid, 1);
    check("R7 cmd_data", cmd_data, 15'h2B61);
    cyc();
    check("R7 pulse one cycle", cmd_valid, 0);
    sel_cmd = 0;

    leave_prog = 1; cyc(); leave_prog = 0;
    check("R5 prog_on dropped", prog_on, 0);
    sel_en = 1;
    shift_bits(16, 16'h0, dout);
    check("R5 register zeroed", dout, 16'h0000);
    sel_en = 0;

    sel_cmd = 1;
    shift_bits(15, 16'h0F0F, dout);
    update_dr = 1; cyc(); update_dr = 0;
    check("R8 no cmd_valid when locked", cmd_valid, 0);
    check("R8 cmd_data kept", cmd_data, 15'h2B61);
    check("R9 tdo from command reg", tdo, 1);
    sel_cmd = 0;
    #1 check("R9 tdo idle again", tdo, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule